// File: doc/BRIEF.md
# Byte-Write / Word-Read SPI Register Slave

This block is the slave side of a four-wire serial port that gives a host access to a bank of 16-bit registers. Each transfer is a 16-bit full-duplex frame framed by an active-low select. A write frame carries a byte address and one data byte, so a full 16-bit register takes two write frames. A read frame carries a byte address. The block fetches the whole 16-bit word that contains that byte and shifts it out during the next frame. A host that reads continuously therefore pays only one extra frame for the whole sequence.

The block runs in a system clock domain that is at least eight times the serial clock. The serial clock, the select and the data input are synchronised into that domain, and their edges are detected there. Clock polarity and phase are both 1: input bits are taken on rising serial-clock edges, and output bits change after falling edges. The first output bit is presented as soon as the select falls.

On the register side the block has three parts: a byte-write strobe with its address and data, a registered word address with a data return, and a one-cycle read-acknowledge pulse. Register owners use the acknowledge to clear the new-data flag (bit 15) or any sticky flag of the word just read. That side has no back-pressure. A write strobe must be accepted in its cycle. The read data must be valid, as a function of the word address, during the acknowledge cycle.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, dout_oe, dout, wr_en and rd_ack are all 0.
- R2: dout_oe is 1 while the select is low and 0 while it is high, allowing for a few system cycles of synchroniser latency. dout is 0 whenever dout_oe is 0.
- R3: A complete frame whose first two bits are 1 then 0 gives exactly one wr_en pulse. wr_addr carries frame bits 13:8 and wr_data carries frame bits 7:0.
- R4: A complete frame whose first two bits are 0 then 0 gives exactly one rd_ack pulse. rd_addr carries frame bits 13:9, so the even and the odd byte address of a pair fetch the same 16-bit word.
- R5: In the frame after a read, dout shifts out the word that rd_data held during the rd_ack cycle, most significant bit first. Bit 15 is already valid before the first falling serial-clock edge and stays unchanged across that edge. Each later bit appears after the next falling edge.
- R6: A frame whose first two bits are 0 then 1, or 1 then 1, gives neither wr_en nor rd_ack.
- R7: In the frame after any complete frame that is not a read, dout shifts out zeros.
- R8: A frame cut short by the select rising before 16 rising edges gives no wr_en and no rd_ack. It leaves the pending read word in place for the next complete frame.
- R9: Serial-clock and data-input activity while the select is high gives no wr_en and no rd_ack. It leaves dout_oe at 0 and leaves the pending read word unchanged.
- R10: In back-to-back read frames, each frame returns the word named by the frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host, 0 while not enabled |
| dout_oe | output | 1 | Output enable for the dout pad driver |
| wr_en | output | 1 | One-cycle byte write strobe |
| wr_addr | output | 6 | Byte address of the write |
| wr_data | output | 8 | Byte written |
| rd_addr | output | 5 | Word address of the pending read |
| rd_data | input | 16 | Word returned by register owners for rd_addr |
| rd_ack | output | 1 | One-cycle pulse: rd_data is captured this cycle |

## Verification
The bench builds the block with its default parameters: a 6-bit byte address, an 8-bit data byte and a two-stage synchroniser. That gives the 16-bit frame and the full 32-word register space. Both byte addresses of the same pair are reached, as is the topmost word (byte address 0x3E). A bench-side register owner clears bit 15 on each acknowledge, so repeated reads of one word show the new-data flag first set and then cleared. With a serial half period of eight system cycles, the synchroniser delay stays well inside each bit time. Cut-short frames and clocking with the select high can then be placed at bit boundaries.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_READ  = 2'd1,
    KIND_BAD   = 2'd2
  } frame_kind_e;

  // The two leading command bits select the frame kind.
  function automatic frame_kind_e classify(input logic [1:0] lead);
    case (lead)
      2'b10:   classify = KIND_WRITE;
      2'b00:   classify = KIND_READ;
      default: classify = KIND_BAD;
    endcase
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  input  logic [WIDTH-1:0] idle,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= idle;
          else     chain[g] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= idle;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= idle;
    else     prev <= chain[STAGES-1];
  end

  assign cur = chain[STAGES-1];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               rise,
  input  logic               bit_in,
  output logic [$clog2(FRAME_W+1)-1:0] count,
  output logic               done,
  output logic [FRAME_W-1:0] frame
);

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      shreg <= '0;
      done  <= 1'b0;
      frame <= '0;
    end else begin
      done <= 1'b0;
      if (!sel) begin
        count <= '0;
      end else if (rise && count != FULL) begin
        shreg <= {shreg[FRAME_W-2:0], bit_in};
        count <= count + 1'b1;
        if (count == LAST) begin
          done  <= 1'b1;
          frame <= {shreg[FRAME_W-2:0], bit_in};
        end
      end
    end
  end

endmodule

// File: rtl/spi_word_tx.sv
module spi_word_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              start,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  output logic              dout,
  output logic              dout_oe
);

  logic [WORD_W-1:0] shreg;
  logic              oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= sel;
      if (start)      shreg <= word;
      else if (shift) shreg <= {shreg[WORD_W-2:0], 1'b0};
    end
  end

  assign dout_oe = oe_q;
  assign dout    = oe_q & shreg[WORD_W-1];

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sclk,
  input  logic                   cs_n,
  input  logic                   din,
  output logic                   dout,
  output logic                   dout_oe,
  output logic                   wr_en,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [DATA_W-1:0]      wr_data,
  output logic [ADDR_W-2:0]      rd_addr,
  input  logic [2*DATA_W-1:0]    rd_data,
  output logic                   rd_ack
);

  import spi_reg_pkg::*;

  localparam int FRAME_W = 2 + ADDR_W + DATA_W;
  localparam int WORD_W  = 2 * DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Synchronised pins: bit 2 = sclk, bit 1 = cs_n, bit 0 = din.
  logic [2:0] s_cur, s_prev;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  ({sclk, cs_n, din}),
    .idle (3'b110),
    .cur  (s_cur),
    .prev (s_prev)
  );

  logic sel, sel_start, sclk_rise, sclk_fall;
  assign sel       = ~s_cur[1];
  assign sel_start = ~s_cur[1] & s_prev[1];
  assign sclk_rise =  s_cur[2] & ~s_prev[2];
  assign sclk_fall = ~s_cur[2] &  s_prev[2];

  logic [CNT_W-1:0]   bit_count;
  logic               frame_done;
  logic [FRAME_W-1:0] frame;

  spi_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .rise   (sclk_rise),
    .bit_in (s_cur[0]),
    .count  (bit_count),
    .done   (frame_done),
    .frame  (frame)
  );

  frame_kind_e kind;
  assign kind = classify(frame[FRAME_W-1 -: 2]);

  logic              fetch_pend;
  logic [WORD_W-1:0] next_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      rd_addr    <= '0;
      fetch_pend <= 1'b0;
      next_word  <= '0;
    end else begin
      wr_en      <= 1'b0;
      fetch_pend <= 1'b0;
      if (fetch_pend) next_word <= rd_data;
      if (frame_done) begin
        case (kind)
          KIND_WRITE: begin
            wr_en     <= 1'b1;
            wr_addr   <= frame[DATA_W +: ADDR_W];
            wr_data   <= frame[DATA_W-1:0];
            next_word <= '0;
          end
          KIND_READ: begin
            rd_addr    <= frame[DATA_W+1 +: ADDR_W-1];
            fetch_pend <= 1'b1;
          end
          default: next_word <= '0;
        endcase
      end
    end
  end

  assign rd_ack = fetch_pend;

  // The first falling edge keeps the MSB that the select edge presented.
  spi_word_tx #(.WORD_W(WORD_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .start   (sel_start),
    .shift   (sclk_fall & sel & (bit_count != '0)),
    .word    (next_word),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic dout,
  input logic dout_oe,
  input logic wr_en,
  input logic rd_ack
);

  localparam int SETTLE = 6;

  logic [3:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= cs_n  ? ((hi_cnt == 4'hF) ? hi_cnt : hi_cnt + 1'b1) : '0;
      lo_cnt <= !cs_n ? ((lo_cnt == 4'hF) ? lo_cnt : lo_cnt + 1'b1) : '0;
    end
  end

  // R2: output disabled and driven low once the select has been high a while
  assert_oe_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt >= SETTLE) |-> (!dout_oe && !dout));

  // R2: output enabled once the select has been low a while
  assert_oe_active_R2: assert property (@(posedge clk) disable iff (rst)
    (lo_cnt >= SETTLE) |-> dout_oe);

  // R9: no register traffic while the select rests high
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt >= SETTLE) |-> (!wr_en && !rd_ack));

  // R3: a write strobe lasts one cycle
  assert_wr_single_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R4: a read acknowledge lasts one cycle
  assert_ack_single_R4: assert property (@(posedge clk) disable iff (rst)
    rd_ack |=> !rd_ack);

  // R6: a frame is either a write or a read, never both
  assert_kind_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_ack));

endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .dout    (dout),
  .dout_oe (dout_oe),
  .wr_en   (wr_en),
  .rd_ack  (rd_ack)
);

// File: tb/tb_spi_reg_slave.sv
`timescale 1ns/1ps
module tb_spi_reg_slave;

  localparam int HALF = 8;
  localparam int NV   = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b1;
  logic        cs_n = 1'b1;
  logic        din = 1'b0;
  logic        dout, dout_oe, wr_en, rd_ack;
  logic [5:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [4:0]  rd_addr;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  spi_reg_slave dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack)
  );

  // Register owner model: byte writes, bit 15 cleared on acknowledge.
  logic [15:0] mem [32];
  initial begin
    for (int i = 0; i < 32; i++)
      mem[i] = 16'h8000 | 16'(i << 8) | 16'(8'hA0 + i);
  end
  assign rd_data = mem[rd_addr];

  int wr_cnt = 0, ack_cnt = 0;
  logic [5:0] last_wa = '0;
  logic [7:0] last_wd = '0;
  logic [4:0] last_ra = '0;
  always @(posedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        wr_cnt  <= wr_cnt + 1;
        last_wa <= wr_addr;
        last_wd <= wr_data;
        if (wr_addr[0]) mem[wr_addr[5:1]][15:8] <= wr_data;
        else            mem[wr_addr[5:1]][7:0]  <= wr_data;
      end
      if (rd_ack) begin
        ack_cnt <= ack_cnt + 1;
        last_ra <= rd_addr;
        mem[rd_addr][15] <= 1'b0;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic first_bit, oe_mid;

  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    first_bit = dout;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      din  = tx[15-i];
      repeat (HALF) @(negedge clk);
      rx[15-i] = dout;
      oe_mid   = dout_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // {tx word, expected word shifted out in the same frame, write?, ack?}
  localparam logic [33:0] VEC [NV] = '{
    {16'h0400, 16'h0000, 1'b0, 1'b1},  // read word 2, nothing pending
    {16'h0500, 16'h82A2, 1'b0, 1'b1},  // odd address of word 2, fresh flag
    {16'h865A, 16'h02A2, 1'b1, 1'b0},  // write byte 6, flag now clear
    {16'h0700, 16'h0000, 1'b0, 1'b1},  // after a write: zeros
    {16'h8712, 16'h835A, 1'b1, 1'b0},  // write byte 7
    {16'h3E00, 16'h0000, 1'b0, 1'b1},  // top word 31
    {16'h0000, 16'h9FBF, 1'b0, 1'b1},  // back-to-back read
    {16'hC6FF, 16'h80A0, 1'b0, 1'b0},  // lead bits 11: ignored
    {16'h0600, 16'h0000, 1'b0, 1'b1},  // after a bad frame: zeros
    {16'h4300, 16'h125A, 1'b0, 1'b0},  // lead bits 01: ignored
    {16'h0600, 16'h0000, 1'b0, 1'b1},
    {16'h0000, 16'h125A, 1'b0, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    int w0, a0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!dout_oe && !dout && !wr_en && !rd_ack, "R1", "outputs after reset",
          {28'd0, dout_oe, dout, wr_en, rd_ack}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      w0 = wr_cnt;
      a0 = ack_cnt;
      xfer(VEC[v][33:18], 16, rx);
      check(rx == VEC[v][17:2], (v == 6) ? "R10" : (v == 3 || v == 8) ? "R7" : "R5",
            $sformatf("vector %0d word", v), {16'd0, rx}, {16'd0, VEC[v][17:2]});
      check((wr_cnt - w0) == int'(VEC[v][1]), "R3", $sformatf("vector %0d writes", v),
            wr_cnt - w0, VEC[v][1]);
      check((ack_cnt - a0) == int'(VEC[v][0]), (VEC[v][0]) ? "R4" : "R6",
            $sformatf("vector %0d acks", v), ack_cnt - a0, VEC[v][0]);
      check(oe_mid == 1'b1 && dout_oe == 1'b0, "R2", $sformatf("vector %0d enable", v),
            {oe_mid, dout_oe}, 2'b10);
      if (v == 1) begin
        check(first_bit == 1'b1, "R5", "MSB before first falling edge", first_bit, 1);
        check(last_ra == 5'd2, "R4", "odd byte address maps to word 2", last_ra, 2);
      end
      if (v == 4)
        check(last_wa == 6'h07 && last_wd == 8'h12, "R3", "write address and data",
              {last_wa, last_wd}, {6'h07, 8'h12});
      if (v == 5)
        check(last_ra == 5'd31, "R4", "top word address", last_ra, 31);
    end

    // R8: frame cut after 8 bits, write to byte 0x0A must not happen
    w0 = wr_cnt;
    a0 = ack_cnt;
    xfer(16'h8A55, 8, rx);
    check(wr_cnt == w0 && ack_cnt == a0, "R8", "cut frame register traffic",
          (wr_cnt - w0) + (ack_cnt - a0), 0);
    xfer(16'h0A00, 16, rx);
    check(rx == 16'h00A0, "R8", "pending word kept across cut frame", rx, 16'h00A0);
    xfer(16'h0000, 16, rx);
    check(rx == 16'h85A5, "R8", "word 5 untouched by cut write", rx, 16'h85A5);

    // R9: clocking with the select high; pending word is word 0
    w0 = wr_cnt;
    a0 = ack_cnt;
    for (int k = 0; k < 20; k++) begin
      sclk = 1'b0;
      din  = k[0];
      repeat (HALF) @(negedge clk);
      check(!dout_oe && !dout, "R9", "output idle while deselected", {dout_oe, dout}, 0);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    check(wr_cnt == w0 && ack_cnt == a0, "R9", "no traffic while deselected",
          (wr_cnt - w0) + (ack_cnt - a0), 0);
    xfer(16'h8000, 16, rx);
    check(rx == 16'h00A0, "R9", "pending word survives idle clocking", rx, 16'h00A0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule